// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Extractor

This block converts an unsigned binary value into a fixed row of decimal digits, ready for a character display to pick up one digit at a time. It contains no divide or modulo operator. A small state machine takes the powers of ten from the largest down. For each power it subtracts that power from a working value for as long as the result stays non-negative, and it counts how many subtractions succeed. That count becomes the digit. Whatever is left over is the working value for the next lower power.

Each cycle the datapath does one compare-and-subtract, so the logic path stays short. The cost is latency: a conversion takes a variable number of cycles, at most a few dozen. A slow display reading the result never notices that delay. The user pulses `start_i` while the block is idle. It then waits for `done_o` and reads `digits_o`. If the input does not fit in the digit row, the block reports overflow and leaves the digits as they were.

Top module: `dec_digit_extractor`

## Requirements
- R1: After reset, `digits_o` is all zeros and `busy_o`, `done_o` and `overflow_o` are low.
- R2: Suppose `start_i` is sampled high while the block is idle and `value_i` is at most 999999. Then `busy_o` is high and `overflow_o` is low in the next cycle.
- R3: Digit entry i occupies `digits_o[4i+3:4i]` and holds the binary value 0 to 9 of one decimal digit. Entry 0 is the most significant digit (the 100000s) and entry 5 is the units, so 365 reads 0,0,0,3,6,5. Leading positions are written as zero, never left stale.
- R4: Each digit costs one cycle per successful subtraction plus one final compare cycle. `busy_o` therefore stays high for exactly (sum of the six digits + 6) cycles, which is never more than 60.
- R5: In the cycle after the units digit is written, `busy_o` is low and `done_o` is high. `done_o` stays high for exactly one cycle.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running conversion finishes with the digits of the value that was first accepted, and no extra conversion follows.
- R7: Suppose a start is accepted while idle and `value_i` exceeds 999999. Then `busy_o` stays low, `overflow_o` and a one-cycle `done_o` appear in the next cycle, and `digits_o` is unchanged. `overflow_o` stays high until the next in-range start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| value_i | input | 20 | Unsigned binary value to convert |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Last accepted value did not fit in six digits |
| digits_o | output | 24 | Six 4-bit decimal digits, entry 0 most significant |

## Verification
The bench builds the block with its default parameters: a 20-bit input and six 4-bit digits. With these settings the top in-range value 999999 and the smallest overflowing value 1000000 are both reachable, and so is the full-scale input 1048575, which all lie within one input width. The six-digit row also brings every digit position to 9, so the 60-cycle worst-case latency can be reached. With all six leading positions in play, a short value following a long one shows whether the leading zeros are rewritten.

// File: rtl/dde_pkg.sv
package dde_pkg;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;

  function automatic logic [63:0] pow10(input int unsigned e);
    logic [63:0] p;
    p = 64'd1;
    for (int unsigned k = 0; k < e; k++) p = p * 64'd10;
    return p;
  endfunction

endpackage

// File: rtl/dde_pow_table.sv
// Power of ten for each digit position, position 0 being the most significant.
module dde_pow_table #(
  parameter int unsigned W          = 20,
  parameter int unsigned NUM_DIGITS = 6,
  parameter int unsigned IDX_W      = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     pow_o
);
  import dde_pkg::*;

  localparam int unsigned SLOTS = 2 ** IDX_W;

  logic [W-1:0] tbl [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_tbl
    if (i < NUM_DIGITS) begin : g_live
      assign tbl[i] = W'(pow10(NUM_DIGITS - 1 - i));
    end else begin : g_pad
      assign tbl[i] = '1;
    end
  end

  assign pow_o = tbl[idx_i];

endmodule

// File: rtl/dde_sub_step.sv
// One compare-and-subtract: ge_o says the subtraction leaves a non-negative value.
module dde_sub_step #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] work_i,
  input  logic [W-1:0] pow_i,
  output logic         ge_o,
  output logic [W-1:0] diff_o
);
  logic [W:0] full;

  assign full   = {1'b0, work_i} - {1'b0, pow_i};
  assign ge_o   = ~full[W];
  assign diff_o = full[W-1:0];

endmodule

// File: rtl/dec_digit_extractor.sv
module dec_digit_extractor #(
  parameter int unsigned IN_W       = 20,
  parameter int unsigned NUM_DIGITS = 6,
  parameter int unsigned DIGIT_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [IN_W-1:0]               value_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          overflow_o,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o
);
  import dde_pkg::*;

  localparam int unsigned IDX_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [63:0] MAX_VAL = pow10(NUM_DIGITS) - 64'd1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam int unsigned RUN_MAX = NUM_DIGITS * 10;
  localparam int unsigned RC_W    = $clog2(RUN_MAX + 2);

  state_e                        state_q;
  logic [IDX_W-1:0]              idx_q;
  logic [IN_W-1:0]               work_q;
  logic [DIGIT_W-1:0]            cnt_q;
  logic [NUM_DIGITS*DIGIT_W-1:0] digits_q;
  logic                          done_q;
  logic                          ovf_q;

  logic [IN_W-1:0] pow;
  logic [IN_W-1:0] diff;
  logic            ge;
  logic            in_range;

  dde_pow_table #(.W(IN_W), .NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_pow (
    .idx_i (idx_q),
    .pow_o (pow)
  );

  dde_sub_step #(.W(IN_W)) u_sub (
    .work_i (work_q),
    .pow_i  (pow),
    .ge_o   (ge),
    .diff_o (diff)
  );

  assign in_range = (64'(value_i) <= MAX_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      work_q   <= '0;
      cnt_q    <= '0;
      digits_q <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (in_range) begin
              work_q  <= value_i;
              idx_q   <= '0;
              cnt_q   <= '0;
              ovf_q   <= 1'b0;
              state_q <= ST_RUN;
            end else begin
              ovf_q  <= 1'b1;
              done_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (ge) begin
            work_q <= diff;
            cnt_q  <= cnt_q + 1'b1;
          end else begin
            digits_q[DIGIT_W*int'(idx_q) +: DIGIT_W] <= cnt_q;
            cnt_q <= '0;
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign overflow_o = ovf_q;
  assign digits_o   = digits_q;

  // Run-length counter used only by the bound check below.
  logic [RC_W-1:0] run_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt_q <= '0;
    else if (busy_o) run_cnt_q <= run_cnt_q + 1'b1;
    else             run_cnt_q <= '0;
  end

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_q <= RC_W'(RUN_MAX));

  // R4
  digit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= DIGIT_W'(9)));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && in_range) |=> (busy_o && !overflow_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !in_range) |=> (overflow_o && done_o && !busy_o && $stable(digits_o)));

  // R3
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dchk
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digits_o[d*DIGIT_W +: DIGIT_W] <= DIGIT_W'(9));
  end

endmodule

// File: tb/dec_digit_extractor_test.sv
module dec_digit_extractor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] value = '0;
  logic        busy, done, ovf;
  logic [23:0] digits;

  always #4 clk = ~clk;

  dec_digit_extractor uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .value_i    (value),
    .busy_o     (busy),
    .done_o     (done),
    .overflow_o (ovf),
    .digits_o   (digits)
  );

  typedef struct {
    logic [23:0] dig;
    bit          ov;
    int          lat;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [23:0] last_dig = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [23:0] to_dig(input int v);
    logic [23:0] r;
    int          p;
    r = '0;
    p = 100000;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'((v / p) % 10);
      p = p / 10;
    end
    return r;
  endfunction

  function automatic int dsum(input logic [23:0] d);
    int s;
    s = 0;
    for (int i = 0; i < 6; i++) s += int'(d[4*i +: 4]);
    return s;
  endfunction

  // Driver: waits for idle, issues one start, pushes the expected outcome.
  task automatic apply(input int v, input bit poke);
    item_t it;
    do @(negedge clk); while (busy || sb.size() != 0 || done);
    if (v > 999999) begin
      it.dig = last_dig;
      it.ov  = 1'b1;
      it.lat = 0;
    end else begin
      it.dig   = to_dig(v);
      it.ov    = 1'b0;
      it.lat   = dsum(it.dig) + 6;
      last_dig = it.dig;
    end
    sb.push_back(it);
    value = 20'(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v <= 999999)
      chk(busy && !ovf, "R2", "busy/ovf after accept", {busy, ovf}, 2'b10);
    if (poke) begin
      repeat (3) @(negedge clk);
      value = 20'd777777;
      start = 1'b1; // R6: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: counts busy cycles and compares each completion against the queue.
  initial begin
    int  bcnt = 0;
    bit  prev_done = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_done) chk(!done, "R5", "done width", done, 0);
        prev_done = done;
        if (busy) bcnt++;
        if (done) begin
          chk(!busy, "R5", "busy at done", busy, 0);
          if (sb.size() == 0) begin
            chk(0, "R6", "unexpected completion", 1, 0);
          end else begin
            it = sb.pop_front();
            chk(digits == it.dig, it.ov ? "R7" : "R3", "digits", digits, it.dig);
            chk(ovf == it.ov, "R7", "overflow", ovf, it.ov);
            chk(bcnt == it.lat, "R4", "busy cycles", bcnt, it.lat);
          end
          bcnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(digits == '0, "R1", "digits at reset", digits, 0);
    chk(!busy, "R1", "busy at reset", busy, 0);
    chk(!done, "R1", "done at reset", done, 0);
    chk(!ovf, "R1", "overflow at reset", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(365, 0);
    apply(0, 0);
    apply(999999, 0);      // worst-case latency, 60 cycles
    apply(42, 0);          // leading positions rewritten as zero
    apply(1000000, 0);     // smallest overflow, digits keep 000042
    apply(1048575, 0);     // full-scale overflow
    apply(7, 0);           // clears overflow
    apply(100000, 0);
    apply(909090, 1);      // R6 start while busy
    apply(555555, 0);
    apply(123456, 1);      // R6
    apply(9, 0);
    apply(10, 0);
    for (int k = 1; k <= 16; k++) apply((k * 371713) % 1000000, 0);

    do @(negedge clk); while (sb.size() != 0 || busy);
    repeat (4) @(negedge clk);
    report();
  end

endmodule